// File: doc/BRIEF.md
# Event Counter Performance Monitor

This block counts hardware events for performance analysis. It holds a bank of four 32-bit counters on a simple register bus, which has an address, a write strobe, write data and combinational read data. Each counter has a configuration word that picks one of 32 single-cycle event inputs. The counter advances by one on each cycle in which its selected event pulses while the unit is switched on.

When a counter wraps from all ones to zero, it sets a sticky overflow flag. Software clears the flag by writing a one to it. The flags whose interrupt enable is set are combined into one interrupt line, and the active level of that line is programmable. Software can also preload any counter or zero it through the control word.

Registers sit at byte addresses on an 8-bit bus: control at 0x00, status at 0x04, counter n at 0x40+4n and configuration n at 0x80+4n.

Top module: `evmon_top`

## Requirements
- R1: After synchronous reset, every register reads 0. With polarity 0 and no flags set, `irq_out` is 1.
- R2: Control bit 0 is the unit enable. While it is 0, no counter advances on events.
- R3: Configuration bits 6:2 hold a code that selects `event_in[code]`. Only codes 3, 4, 6, 8 and 15 count. Every other code, including 0, leaves the counter unchanged.
- R4: A counter whose selected event pulses while the unit is enabled goes up by exactly 1 at that clock edge. Reading 0x40+4n returns the live count. Writing 0x40+4n loads the value, and a load wins over a same-cycle event.
- R5: An increment from 0xFFFFFFFF to 0 sets status bit n. The flag stays set until software clears it, and a counter load or zeroing leaves it in place.
- R6: Writing status (0x04) with bit n = 1 clears flag n, and bits written 0 have no effect. If a wrap and a clear hit the same flag in one cycle, the flag ends up set.
- R7: Writing control with bit 8+n = 1 zeroes counter n at that edge. Bits 11:8 always read back 0, and the zeroing wins over a same-cycle event.
- R8: `irq_out` is the OR over n of (flag n AND configuration bit 0 of counter n). It is driven as is when control bit 2 is 1 and inverted when control bit 2 is 0.
- R9: Control reads back only bits 0 and 2, and configuration reads back only bits 0 and 6:2. All other bits read 0. Writes to unmapped addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| event_in | input | 32 | Event pulses, one cycle each |
| irq_out | output | 1 | Overflow interrupt, level set by control bit 2 |

## Verification
Read data is combinational, so a register's value is due on `bus_rdata` as soon as `bus_addr` settles. Writes and event pulses change state at the next rising edge, and `irq_out` follows the flags without added delay. The bench drives bus and events just after a falling edge. It compares every register and the interrupt one time unit after the following rising edge, with the write strobe already lowered, against a model advanced by exactly one edge.

// File: rtl/evmon_pkg.sv
package evmon_pkg;

    localparam int EV_NCNT   = 4;
    localparam int EV_CW     = 32;
    localparam int EV_AW     = 8;
    localparam int EV_DW     = 32;
    localparam int EV_NEV    = 32;
    localparam int EV_SELW   = 5;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_POL_BIT  = 2;
    localparam int CTRL_ZERO_LSB = 8;
    localparam int CFG_IE_BIT    = 0;
    localparam int CFG_CODE_LSB  = 2;

    localparam logic [EV_AW-1:0] ADDR_CTRL = 8'h00;
    localparam logic [EV_AW-1:0] ADDR_STAT = 8'h04;
    localparam logic [EV_AW-1:0] CNT_BASE  = 8'h40;
    localparam logic [EV_AW-1:0] CFG_BASE  = 8'h80;

    typedef struct packed {
        logic [EV_SELW-1:0] code;
        logic               ie;
    } evcfg_t;

    typedef struct packed {
        logic en;
        logic pol;
    } ctrl_t;

    function automatic logic code_valid(input logic [EV_SELW-1:0] c);
        case (c)
            5'd3, 5'd4, 5'd6, 5'd8, 5'd15: return 1'b1;
            default:                       return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/evmon_slice.sv
module evmon_slice
    import evmon_pkg::*;
#(
    parameter int CW  = EV_CW,
    parameter int NEV = EV_NEV
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          unit_en,
    input  logic [NEV-1:0] event_in,
    input  logic          cfg_we,
    input  evcfg_t        cfg_wdata,
    input  logic          cnt_we,
    input  logic [CW-1:0] cnt_wdata,
    input  logic          zero_req,
    input  logic          flag_clr,
    output logic [CW-1:0] count,
    output evcfg_t        cfg,
    output logic          flag
);

    logic hit;
    logic wrap;

    always_comb begin
        hit  = unit_en && code_valid(cfg.code) && event_in[cfg.code];
        wrap = hit && !cnt_we && !zero_req && (count == {CW{1'b1}});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            cfg   <= '0;
            flag  <= 1'b0;
        end else begin
            if (cfg_we) cfg <= cfg_wdata;
            if (cnt_we)        count <= cnt_wdata;
            else if (zero_req) count <= '0;
            else if (hit)      count <= count + 1'b1;
            if (wrap)          flag <= 1'b1;
            else if (flag_clr) flag <= 1'b0;
        end
    end

    // R2: disabled unit holds the count
    p_hold_disabled_r2: assert property (@(posedge clk) disable iff (rst)
        (!unit_en && !cnt_we && !zero_req) |=> $stable(count));
    // R3: an unlisted code never advances the count
    p_bad_code_r3: assert property (@(posedge clk) disable iff (rst)
        (!code_valid(cfg.code) && !cnt_we && !zero_req) |=> $stable(count));
    // R5: wrap raises the flag even against a clear (R6)
    p_wrap_flag_r5: assert property (@(posedge clk) disable iff (rst)
        (hit && !cnt_we && !zero_req && count == {CW{1'b1}}) |=> flag);
    // R5: flag is sticky without a clear
    p_flag_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (flag && !flag_clr) |=> flag);
    // R7: zero request clears the count
    p_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (zero_req && !cnt_we) |=> (count == '0));

endmodule

// File: rtl/evmon_irq.sv
module evmon_irq #(
    parameter int N = 4
) (
    input  logic [N-1:0] flags,
    input  logic [N-1:0] ies,
    input  logic         pol,
    output logic         irq
);

    logic any_pending;

    always_comb begin
        any_pending = |(flags & ies);
        irq = pol ? any_pending : !any_pending;
    end

endmodule

// File: rtl/evmon_top.sv
module evmon_top
    import evmon_pkg::*;
#(
    parameter int NCNT = EV_NCNT,
    parameter int CW   = EV_CW,
    parameter int AW   = EV_AW,
    parameter int DW   = EV_DW,
    parameter int NEV  = EV_NEV
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_we,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [NEV-1:0] event_in,
    output logic          irq_out
);

    localparam int STRIDE = 4;

    ctrl_t           ctrl_q;
    logic            wr_ctrl;
    logic            wr_stat;
    logic [NCNT-1:0] flags;
    logic [NCNT-1:0] ies;
    logic [CW-1:0]   counts [NCNT];
    evcfg_t          cfgs   [NCNT];
    evcfg_t          cfg_wval;

    assign wr_ctrl  = bus_we && (bus_addr == ADDR_CTRL);
    assign wr_stat  = bus_we && (bus_addr == ADDR_STAT);
    assign cfg_wval = '{code: bus_wdata[CFG_CODE_LSB +: EV_SELW], ie: bus_wdata[CFG_IE_BIT]};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q.en  <= bus_wdata[CTRL_EN_BIT];
            ctrl_q.pol <= bus_wdata[CTRL_POL_BIT];
        end
    end

    for (genvar n = 0; n < NCNT; n++) begin : g_slice
        localparam logic [AW-1:0] CADDR = CNT_BASE + AW'(n * STRIDE);
        localparam logic [AW-1:0] FADDR = CFG_BASE + AW'(n * STRIDE);

        evmon_slice #(.CW(CW), .NEV(NEV)) u_slice (
            .clk       (clk),
            .rst       (rst),
            .unit_en   (ctrl_q.en),
            .event_in  (event_in),
            .cfg_we    (bus_we && bus_addr == FADDR),
            .cfg_wdata (cfg_wval),
            .cnt_we    (bus_we && bus_addr == CADDR),
            .cnt_wdata (bus_wdata[CW-1:0]),
            .zero_req  (wr_ctrl && bus_wdata[CTRL_ZERO_LSB + n]),
            .flag_clr  (wr_stat && bus_wdata[n]),
            .count     (counts[n]),
            .cfg       (cfgs[n]),
            .flag      (flags[n])
        );
        assign ies[n] = cfgs[n].ie;
    end

    evmon_irq #(.N(NCNT)) u_irq (
        .flags (flags),
        .ies   (ies),
        .pol   (ctrl_q.pol),
        .irq   (irq_out)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_CTRL) begin
            bus_rdata[CTRL_EN_BIT]  = ctrl_q.en;
            bus_rdata[CTRL_POL_BIT] = ctrl_q.pol;
        end else if (bus_addr == ADDR_STAT) begin
            bus_rdata[NCNT-1:0] = flags;
        end
        for (int n = 0; n < NCNT; n++) begin
            if (bus_addr == CNT_BASE + AW'(n * STRIDE))
                bus_rdata[CW-1:0] = counts[n];
            if (bus_addr == CFG_BASE + AW'(n * STRIDE)) begin
                bus_rdata[CFG_IE_BIT] = cfgs[n].ie;
                bus_rdata[CFG_CODE_LSB +: EV_SELW] = cfgs[n].code;
            end
        end
    end

    // R8: interrupt asserted level matches a pending enabled flag
    p_irq_level_r8: assert property (@(posedge clk) disable iff (rst)
        ((|(flags & ies)) && ctrl_q.pol) |-> irq_out);
    // R1: one edge after reset the interrupt is idle-high with polarity 0
    p_reset_irq_r1: assert property (@(posedge clk)
        $past(rst) |-> (irq_out && flags == '0));

endmodule

// File: tb/evmon_top_bench.sv
module evmon_top_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  bus_addr;
    logic        bus_we;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [31:0] event_in;
    logic        irq_out;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_cnt  [4];
    logic [4:0]  m_code [4];
    logic [3:0]  m_flag;
    logic [3:0]  m_ie;
    logic        m_en;
    logic        m_pol;

    always #(CLK_PERIOD/2) clk = ~clk;

    evmon_top u_evmon_top (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .event_in(event_in), .irq_out(irq_out)
    );

    function automatic bit mvalid(input logic [4:0] c);
        return (c == 3) || (c == 4) || (c == 6) || (c == 8) || (c == 15);
    endfunction

    function automatic logic exp_irq();
        logic any;
        any = |(m_flag & m_ie);
        return m_pol ? any : !any;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_we   = 1'b0;
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic check_all();
        logic [31:0] d;
        rd(8'h00, d); chk("R9 ctrl", d, {29'd0, m_pol, 1'b0, m_en});
        rd(8'h04, d); chk("R5 status", d, {28'd0, m_flag});
        for (int n = 0; n < 4; n++) begin
            rd(8'h40 + 8'(4*n), d); chk("R4 count", d, m_cnt[n]);
            rd(8'h80 + 8'(4*n), d); chk("R9 cfg", d, {25'd0, m_code[n], 1'b0, m_ie[n]});
        end
        chk("R8 irq", {31'd0, irq_out}, {31'd0, exp_irq()});
    endtask

    task automatic cycle(input logic [7:0] a, input logic we, input logic [31:0] wd,
                         input logic [31:0] ev);
        logic [31:0] nc [4];
        logic [3:0]  nf;
        logic        hit, cw, zr, wrap;
        @(negedge clk);
        bus_addr = a; bus_we = we; bus_wdata = wd; event_in = ev;
        nf = m_flag;
        for (int n = 0; n < 4; n++) begin
            hit  = m_en && mvalid(m_code[n]) && ev[m_code[n]];
            cw   = we && (a == 8'h40 + 8'(4*n));
            zr   = we && (a == 8'h00) && wd[8+n];
            nc[n] = cw ? wd : zr ? 32'd0 : hit ? m_cnt[n] + 1 : m_cnt[n];
            wrap = hit && !cw && !zr && (m_cnt[n] == 32'hFFFF_FFFF);
            if (wrap) nf[n] = 1'b1;
            else if (we && a == 8'h04 && wd[n]) nf[n] = 1'b0;
        end
        @(posedge clk);
        for (int n = 0; n < 4; n++) begin
            m_cnt[n] = nc[n];
            if (we && a == 8'h80 + 8'(4*n)) begin
                m_ie[n] = wd[0];
                m_code[n] = wd[6:2];
            end
        end
        m_flag = nf;
        if (we && a == 8'h00) begin
            m_en = wd[0];
            m_pol = wd[2];
        end
        #1;
        bus_we = 1'b0; event_in = '0;
        check_all();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [4:0]  codes [9];
        codes = '{5'd0, 5'd3, 5'd4, 5'd6, 5'd8, 5'd15, 5'd1, 5'd31, 5'd7};
        void'($urandom(32'd20240611));
        for (int n = 0; n < 4; n++) begin m_cnt[n] = 0; m_code[n] = 0; end
        m_flag = 0; m_ie = 0; m_en = 0; m_pol = 0;
        rst = 1'b1; bus_addr = 0; bus_we = 0; bus_wdata = 0; event_in = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R1: reset state
        #1; check_all();
        chk("R1 irq idle", {31'd0, irq_out}, 32'd1);

        // R2: events while disabled do nothing
        cycle(8'h80, 1, {25'd0, 5'd3, 2'b01}, 0);
        cycle(8'h00, 0, 0, 32'hFFFF_FFFF);
        rd(8'h40, d); chk("R2 disabled hold", d, 32'd0);

        // R3: valid vs invalid code
        cycle(8'h84, 1, {25'd0, 5'd5, 2'b00}, 0);
        cycle(8'h00, 1, 32'h1, 0);
        cycle(8'h00, 0, 0, 32'hFFFF_FFFF);
        rd(8'h40, d); chk("R3 valid code counts", d, 32'd1);
        rd(8'h44, d); chk("R3 invalid code holds", d, 32'd0);

        // R4: load wins over same-cycle event
        cycle(8'h40, 1, 32'hFFFF_FFFF, 32'h8);
        rd(8'h40, d); chk("R4 load wins", d, 32'hFFFF_FFFF);

        // R6: wrap and clear together -> flag set
        cycle(8'h04, 1, 32'hF, 32'h8);
        rd(8'h04, d); chk("R6 set wins", d[0], 1'b1);
        rd(8'h40, d); chk("R5 wrap to zero", d, 32'd0);

        // R8: polarity high with enabled flag
        cycle(8'h00, 1, 32'h5, 0);
        chk("R8 active high", {31'd0, irq_out}, 32'd1);

        // R7: zero bit with event, readback 0, flag kept
        cycle(8'h40, 1, 32'd77, 0);
        cycle(8'h00, 1, 32'h105, 32'h8);
        rd(8'h40, d); chk("R7 zeroed", d, 32'd0);
        rd(8'h00, d); chk("R7 bits read 0", d[11:8], 0);
        rd(8'h04, d); chk("R5 flag kept", d[0], 1'b1);

        // R6: clear by write-one
        cycle(8'h04, 1, 32'h1, 0);
        rd(8'h04, d); chk("R6 cleared", d[0], 1'b0);

        // R9: unmapped write ignored
        cycle(8'h30, 1, 32'hFFFF_FFFF, 0);

        for (int i = 0; i < 3000; i++) begin
            int op;
            int k;
            logic [31:0] ev;
            op = $urandom % 16;
            k  = $urandom % 4;
            ev = $urandom;
            case (op)
                6:  cycle(8'h00, 1, (($urandom % 16) << 8) | ($urandom & 32'h4) |
                          (($urandom % 8) != 0 ? 32'h1 : 32'h0), ev);
                7:  cycle(8'h04, 1, $urandom % 16, ev);
                8, 9: cycle(8'h40 + 8'(4*k), 1, 32'hFFFF_FFFF - ($urandom % 4), ev);
                10, 11: cycle(8'h80 + 8'(4*k), 1,
                              {25'd0, codes[$urandom % 9], 1'b0, 1'($urandom)}, ev);
                12: cycle(8'h30 + 8'($urandom % 8), 1, $urandom, ev);
                default: cycle(8'h00, 0, 0, ev);
            endcase
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule